// File: doc/BRIEF.md
# Compare-to-condition-field unit

This unit carries out the four integer compare forms of a 32-bit load/store core. Two of them take a second register, and two take a 16-bit immediate from the instruction word. Either kind can treat its operands as two's-complement or as unsigned. The decoder upstream has already read the register file. It presents the instruction word, operand A, operand B, the summary-overflow flag and the current condition register, and it marks the request with a valid strobe and a two-bit kind select.

The unit builds a 4-bit result code. It holds exactly one of the less-than, greater-than and equal bits, plus a copy of the summary-overflow flag. The code is spliced into one of the eight nibbles of the condition register, and the other 28 bits are passed through unchanged.

An instruction with the 64-bit-compare bit set is an illegal form here. It produces no write and raises a flag. All results come out of registers one cycle after the request.

Top module: `cmp_field_unit`

## Requirements
- R1: While `rst_n` is low, and on the first edge after release with no request, `cr_next` is 0 and both `cr_we` and `bad_form` are 0.
- R2: The destination nibble index n is `insn[25:23]`. Nibble n occupies condition bits 31-4n down to 28-4n, so n=0 is the topmost nibble.
- R3: Inside the written nibble the bits weigh 8 for less-than, 4 for greater-than, 2 for equal and 1 for overflow-copy. Exactly one of the 8, 4 and 2 bits is set.
- R4: The weight-1 bit of the written nibble equals `sum_ovf` as sampled with the request.
- R5: Kind 2'b00 compares `opnd_a` with `opnd_b` as two's-complement numbers.
- R6: Kind 2'b10 compares `opnd_a` with `opnd_b` as unsigned numbers.
- R7: Kind 2'b01 compares `opnd_a` as two's-complement with `insn[15:0]` sign-extended to 32 bits. `opnd_b` has no effect.
- R8: Kind 2'b11 compares `opnd_a` as unsigned with `insn[15:0]` zero-extended to 32 bits. `opnd_b` has no effect.
- R9: On a write, every bit of `cr_next` outside the destination nibble equals the matching bit of `cr_cur`.
- R10: When `insn[21]` is 1, the result shows `cr_we`=0 and `bad_form`=1, and `cr_next` equals `cr_cur` unchanged.
- R11: The results of a request appear on the clock edge that samples it, and the pulse on `cr_we` or `bad_form` lasts exactly one cycle.
- R12: After an edge with `in_valid` low, `cr_we` and `bad_form` are 0 and `cr_next` keeps its previous value, whatever `cr_cur` does.
- R13: Bits of `insn` other than 25..23, 21 and 15..0 do not affect any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_kind | input | 2 | Compare kind: bit 1 unsigned, bit 0 immediate |
| insn | input | 32 | Instruction word |
| opnd_a | input | 32 | First operand value |
| opnd_b | input | 32 | Second operand value (register kinds) |
| sum_ovf | input | 1 | Summary-overflow flag |
| cr_cur | input | 32 | Current condition register |
| cr_next | output | 32 | Updated condition register (registered) |
| cr_we | output | 1 | Write enable for `cr_next` (registered) |
| bad_form | output | 1 | Illegal-form flag (registered) |

## Verification
Two things can happen in the same cycle: the illegal-form check and a fully formed compare result. The bench sends requests that have bit 21 set together with operands, a field index and an overflow flag that would produce a visible nibble. It then judges that the enable stays low, the flag rises and the register comes back bit-for-bit unchanged. Field placement and sign handling meet on the same request too. Directed cases put operands such as all-ones against one into nibbles 0 and 7 under both signed and unsigned kinds, and seeded random traffic mixes the kind, the field, the overflow flag and the unused instruction bits.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;
  localparam int XLEN      = 32;
  localparam int FLDW      = 4;
  localparam int NFLD      = XLEN / FLDW;
  localparam int SELW      = $clog2(NFLD);
  localparam int IMMW      = 16;
  localparam int FSEL_LSB  = 23;
  localparam int LFORM_BIT = 21;

  // bit 1: unsigned, bit 0: immediate
  typedef enum logic [1:0] {
    CK_SREG = 2'b00,
    CK_SIMM = 2'b01,
    CK_UREG = 2'b10,
    CK_UIMM = 2'b11
  } cmp_kind_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } rel_t;

  function automatic logic [XLEN-1:0] widen_imm(input logic [IMMW-1:0] imm,
                                                 input logic sx);
    logic fill;
    fill = sx & imm[IMMW-1];
    return {{(XLEN-IMMW){fill}}, imm};
  endfunction

  // Signed order equals unsigned order after inverting both sign bits.
  function automatic rel_t relate(input logic [XLEN-1:0] a,
                                  input logic [XLEN-1:0] b,
                                  input logic as_signed);
    logic [XLEN-1:0] flip;
    logic [XLEN-1:0] ua;
    logic [XLEN-1:0] ub;
    rel_t r;
    flip = {as_signed, {(XLEN-1){1'b0}}};
    ua   = a ^ flip;
    ub   = b ^ flip;
    r.lt = (ua < ub);
    r.gt = (ua > ub);
    r.eq = (ua == ub);
    return r;
  endfunction

  function automatic logic [FLDW-1:0] pack_nibble(input rel_t r, input logic so);
    return {r.lt, r.gt, r.eq, so};
  endfunction
endpackage

// File: rtl/cmpf_opsel.sv
module cmpf_opsel
  import cmpf_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int IW = IMMW
) (
  input  logic [1:0]    kind,
  input  logic [W-1:0]  reg_b,
  input  logic [IW-1:0] imm,
  output logic [W-1:0]  rhs,
  output logic          as_signed
);
  logic use_imm;
  logic [W-1:0] imm_wide;

  assign use_imm   = kind[0];
  assign as_signed = ~kind[1];

  always_comb begin
    imm_wide = {{(W-IW){as_signed & imm[IW-1]}}, imm};
    rhs      = use_imm ? imm_wide : reg_b;
  end
endmodule

// File: rtl/cmpf_relate.sv
module cmpf_relate
  import cmpf_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         as_signed,
  output rel_t         rel
);
  assign rel = relate(a, b, as_signed);
endmodule

// File: rtl/cmpf_merge.sv
module cmpf_merge
  import cmpf_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int FW = FLDW,
  parameter int NF = W / FW,
  parameter int SW = $clog2(NF)
) (
  input  logic [W-1:0]  cr_in,
  input  logic [SW-1:0] sel,
  input  logic [FW-1:0] nib,
  output logic [W-1:0]  cr_out,
  output logic [W-1:0]  dest_mask
);
  // field f sits at the top of the word for f = 0
  for (genvar f = 0; f < NF; f++) begin : g_fld
    localparam int LO = W - FW * (f + 1);
    logic hit;
    assign hit = (sel == SW'(f));
    assign cr_out[LO +: FW]    = hit ? nib : cr_in[LO +: FW];
    assign dest_mask[LO +: FW] = {FW{hit}};
  end
endmodule

// File: rtl/cmp_field_unit.sv
module cmp_field_unit
  import cmpf_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int FW = FLDW,
  parameter int IW = IMMW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   in_kind,
  input  logic [W-1:0] insn,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         sum_ovf,
  input  logic [W-1:0] cr_cur,
  output logic [W-1:0] cr_next,
  output logic         cr_we,
  output logic         bad_form
);
  localparam int NF = W / FW;
  localparam int SW = $clog2(NF);

  logic [SW-1:0] fsel;
  logic          l_form;
  logic [W-1:0]  rhs;
  logic          as_signed;
  rel_t          rel;
  logic [FW-1:0] nib;
  logic [W-1:0]  merged;
  logic [W-1:0]  dest_mask;
  logic [W-1:0]  so_mask;
  logic          do_write;
  logic          do_reject;
  logic          insn_unused;

  assign fsel        = insn[FSEL_LSB +: SW];
  assign l_form      = insn[LFORM_BIT];
  assign insn_unused = ^{insn[W-1:FSEL_LSB+SW], insn[FSEL_LSB-1:LFORM_BIT+1],
                         insn[LFORM_BIT-1:IW]};

  cmpf_opsel #(.W(W), .IW(IW)) u_opsel (
    .kind      (in_kind),
    .reg_b     (opnd_b),
    .imm       (insn[IW-1:0]),
    .rhs       (rhs),
    .as_signed (as_signed)
  );

  cmpf_relate #(.W(W)) u_rel (
    .a         (opnd_a),
    .b         (rhs),
    .as_signed (as_signed),
    .rel       (rel)
  );

  assign nib = pack_nibble(rel, sum_ovf);

  cmpf_merge #(.W(W), .FW(FW), .NF(NF), .SW(SW)) u_merge (
    .cr_in     (cr_cur),
    .sel       (fsel),
    .nib       (nib),
    .cr_out    (merged),
    .dest_mask (dest_mask)
  );

  assign so_mask   = dest_mask & ~(dest_mask << 1);
  assign do_write  = in_valid & ~l_form;
  assign do_reject = in_valid & l_form;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_next  <= '0;
      cr_we    <= 1'b0;
      bad_form <= 1'b0;
    end else begin
      cr_we    <= do_write;
      bad_form <= do_reject;
      if (do_write)       cr_next <= merged;
      else if (do_reject) cr_next <= cr_cur;
    end
  end

  // R3
  one_relation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $countones({rel.lt, rel.gt, rel.eq}) == 1);

  // R3
  eq_matches_operands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rel.eq) |-> (opnd_a == rhs));

  // R10
  exclusive_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cr_we && bad_form));

  // R10
  reject_keeps_cr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_form |-> cr_next == $past(cr_cur));

  // R9
  outside_field_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> ((cr_next ^ $past(cr_cur)) & ~$past(dest_mask)) == '0);

  // R4
  so_copied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> (|(cr_next & $past(so_mask))) == $past(sum_ovf));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid) |=> (!cr_we && !bad_form && $stable(cr_next)));

  // R11
  write_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_we || bad_form) |-> $past(in_valid));
endmodule

// File: tb/cmp_field_unit_tb.sv
module cmp_field_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_kind;
  logic [31:0] insn;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic        sum_ovf;
  logic [31:0] cr_cur;
  logic [31:0] cr_next;
  logic        cr_we;
  logic        bad_form;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  cmp_field_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .insn(insn), .opnd_a(opnd_a), .opnd_b(opnd_b), .sum_ovf(sum_ovf),
    .cr_cur(cr_cur), .cr_next(cr_next), .cr_we(cr_we), .bad_form(bad_form)
  );

  function automatic logic [31:0] mk_insn(int fld, bit lbit, logic [15:0] imm);
    return (32'(fld & 7) << 23) | (32'(lbit) << 21) | {16'h0, imm};
  endfunction

  function automatic logic [31:0] model_cr(logic [1:0] k, logic [31:0] ins,
                                           logic [31:0] a, logic [31:0] b,
                                           logic so, logic [31:0] cr);
    logic [31:0] bv;
    logic lt, gt, eq;
    int sh;
    logic [31:0] nibv;
    if (k[0]) bv = k[1] ? {16'h0, ins[15:0]} : {{16{ins[15]}}, ins[15:0]};
    else      bv = b;
    if (k[1]) begin
      lt = a < bv; gt = a > bv;
    end else begin
      lt = $signed(a) < $signed(bv); gt = $signed(a) > $signed(bv);
    end
    eq = (a == bv);
    sh = 28 - 4 * int'(ins[25:23]);
    nibv = {28'h0, lt, gt, eq, so};
    return (cr & ~(32'hF << sh)) | (nibv << sh);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at a falling edge with results checked
  task automatic one_req(string req, logic [1:0] k, logic [31:0] ins,
                         logic [31:0] a, logic [31:0] b, logic so, logic [31:0] cr);
    logic [31:0] expv;
    in_valid = 1'b1; in_kind = k; insn = ins; opnd_a = a; opnd_b = b;
    sum_ovf = so; cr_cur = cr;
    expv = ins[21] ? cr : model_cr(k, ins, a, b, so, cr);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " cr_next"}, cr_next, expv);
    chk({req, " cr_we"}, 32'(cr_we), 32'(!ins[21]));
    chk({req, " bad_form"}, 32'(bad_form), 32'(ins[21]));
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    logic [31:0] ins;
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0; in_kind = 2'b00; insn = '0;
    opnd_a = '0; opnd_b = '0; sum_ovf = 1'b0; cr_cur = 32'hDEAD_BEEF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    chk("R1 cr_next", cr_next, 32'h0);
    chk("R1 cr_we", 32'(cr_we), 32'h0);
    chk("R1 bad_form", 32'(bad_form), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {cr_next[30:0], cr_we}, 32'h0);

    // R5 signed register: all-ones is -1, below 1
    one_req("R5", 2'b00, mk_insn(0, 0, 16'h0), 32'hFFFF_FFFF, 32'h1, 1'b0, 32'h0);
    chk("R5 field0 LT", cr_next, 32'h8000_0000);
    // R6 unsigned register: same operands give greater-than
    one_req("R6", 2'b10, mk_insn(7, 0, 16'h0), 32'hFFFF_FFFF, 32'h1, 1'b0, 32'h0);
    chk("R6 field7 GT", cr_next, 32'h0000_0004);
    // R3 equal plus R4 overflow copy into field 3
    one_req("R3", 2'b00, mk_insn(3, 0, 16'h0), 32'h1234_5678, 32'h1234_5678, 1'b1, 32'hFFFF_FFFF);
    chk("R4 EQ|SO nibble", cr_next, 32'hFFF3_FFFF);
    // R7 sign-extended imm 0xFFFF equals -1, opnd_b junk
    one_req("R7", 2'b01, mk_insn(1, 0, 16'hFFFF), 32'hFFFF_FFFF, 32'h0BAD_0BAD, 1'b0, 32'h0);
    chk("R7 EQ", cr_next, 32'h0200_0000);
    // R8 zero-extended imm 0xFFFF, A=-1 unsigned is greater
    one_req("R8", 2'b11, mk_insn(2, 0, 16'hFFFF), 32'hFFFF_FFFF, 32'h0, 1'b0, 32'h0);
    chk("R8 GT", cr_next, 32'h0040_0000);
    one_req("R8 eq", 2'b11, mk_insn(2, 0, 16'h8000), 32'h0000_8000, 32'hFFFF_FFFF, 1'b1, 32'h0);
    // R7 signed imm 0x8000 is -32768, A=0 greater
    one_req("R7 neg", 2'b01, mk_insn(6, 0, 16'h8000), 32'h0, 32'h0, 1'b0, 32'hA5A5_A5A5);
    // R2 boundary field 7 and field 0 with preserved neighbours (R9)
    one_req("R9", 2'b00, mk_insn(7, 0, 16'h0), 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 32'h1234_5670);
    chk("R9 neighbours", cr_next, 32'h1234_5679);
    // R10 illegal form with a result that would otherwise show
    one_req("R10", 2'b00, mk_insn(4, 1, 16'h0), 32'h5, 32'h9, 1'b1, 32'hCAFE_F00D);
    // R13 upper opcode bits set, result unchanged
    one_req("R13", 2'b10, mk_insn(5, 0, 16'h0) | 32'hFC40_0000 | 32'h001F_0000,
            32'h3, 32'h2, 1'b0, 32'h0);
    chk("R13 GT field5", cr_next, 32'h0000_0400);

    // R12 idle: cr_cur moves, outputs hold
    held = cr_next;
    cr_cur = 32'h7777_7777;
    @(posedge clk); @(negedge clk);
    chk("R12 hold", cr_next, held);
    chk("R12 we/flag low", {30'h0, cr_we, bad_form}, 32'h0);
    // R11 pulse width: one cycle after the request
    one_req("R11", 2'b00, mk_insn(1, 0, 16'h0), 32'h1, 32'h2, 1'b0, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R11 single pulse", 32'(cr_we), 32'h0);

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] k;
      logic [31:0] a, b;
      k   = 2'($urandom);
      ins = $urandom;
      ins[21] = ($urandom_range(7) == 0);
      a = $urandom;
      b = ($urandom_range(3) == 0) ? a : $urandom;
      if (k[0] && $urandom_range(3) == 0) a = k[1] ? {16'h0, ins[15:0]} : {{16{ins[15]}}, ins[15:0]};
      one_req(ins[21] ? "R10 rnd" : (k[1] ? "R6/R8 rnd" : "R5/R7 rnd"),
              k, ins, a, b, 1'($urandom), $urandom);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule